// File: doc/BRIEF.md
# Double-Buffered Peripheral DMA Channel

This block is one DMA channel that streams data between system memory and a single fixed peripheral. It holds two buffer descriptors, each made of a start address and a byte count. While one buffer is being moved, software can load the other one. When the active buffer runs out, the channel moves on to the other buffer in the very next cycle, provided that buffer has been started. Each data beat is one or two bytes wide. Beats are paced by a peripheral request line, grouped into bursts of four or eight, and carried on a memory port that uses a simple request/acknowledge handshake with an error response.

Software reaches the channel through a small register port. The control word has three addresses: one where written 1s set bits, one where written 1s clear bits, and one that reads the word back. Completion flags and an error flag feed a single interrupt that has its own enable. A readback register reports the address of the buffer currently in progress. An output tells software which buffer it should load next.

Top module: `dbuf_dma_chan`

## Requirements
- R1: After reset, the setup register, both buffer registers, the readback address and the control word all read 0. The outputs `irq`, `mem_req` and `load_sel` are 0.
- R2: The control word has these bits: run at bit 0, interrupt enable at 1, error at 2, done A at 3, start A at 4, done B at 5, start B at 6 and buffer-in-use at 7 (1 means B is active). Writing offset 0x04 sets each bit given as 1. Writing offset 0x08 clears each bit given as 1. Offset 0x0C reads the word. Bits written as 0 are left unchanged. Bit 7 is changed only by the hardware.
- R3: A beat is a cycle with `mem_req` and `mem_ack` high and `mem_err` low. `mem_req` is high only when all of these hold: run is 1, the active buffer is started, its count is nonzero and `per_req` is 1. Each beat advances the active buffer's address by the beat size and lowers its count by the same amount, saturating at 0. The beat size is 2 when setup bit 3 is 1 and 1 when it is 0. `mem_we` follows setup bit 0 (1 means peripheral to memory).
- R4: When the active buffer's count reaches 0, its done bit is set and its start bit is cleared on the same edge. If the other buffer is started, in-use toggles and beats continue in the next cycle. Otherwise the channel holds. While running, an unstarted active buffer gives way to a started other buffer. A buffer started with count 0 completes without issuing any beat.
- R5: `irq` is 1 exactly when interrupt enable is 1 and at least one of error, done A and done B is 1.
- R6: `load_sel` is 0 (buffer A) when (in-use = 1 and start B = 1) or (in-use = 0 and start A = 0). In all other cases it is 1 (buffer B).
- R7: Offset 0x20 returns buffer A's current address when (in-use = 0 and start A = 1) or (in-use = 1 and start B = 0). In all other cases it returns buffer B's current address.
- R8: Clearing run stops requests and leaves both buffers' addresses and counts unchanged. Setting run again finishes the remaining bytes with no loss and no repeat.
- R9: A memory acknowledge that comes with `mem_err` sets the error bit and clears run. That beat does not advance the buffer.
- R10: `per_burst_end` pulses on the beat that completes a burst and on the final beat of a buffer. The burst length is 8 beats when setup bit 2 is 1 and 4 beats when it is 0.
- R11: When setup bit 3 = 1 and setup bit 1 = 1 (16-bit, big-endian), the two bytes are swapped on both data paths (`mem_rdata` to `per_wdata` and `per_rdata` to `mem_wdata`). Otherwise data passes through unchanged.
- R12: `per_sel` is setup bits 7:4 and `per_addr` is the setup bits above bit 7. Offset 0x00 writes and reads the setup register, 0x10 and 0x14 give buffer A's address and count, and 0x18 and 0x1C give buffer B's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 6 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| irq | output | 1 | Interrupt request |
| load_sel | output | 1 | Buffer software should load next (0 = A, 1 = B) |
| mem_req | output | 1 | Memory beat request |
| mem_ack | input | 1 | Memory beat accepted |
| mem_err | input | 1 | Error response qualifying mem_ack |
| mem_addr | output | 32 | Active buffer address |
| mem_we | output | 1 | 1 = write to memory |
| mem_wide | output | 1 | 1 = 16-bit beat |
| mem_wdata | output | 16 | Data toward memory |
| mem_rdata | input | 16 | Data from memory |
| per_req | input | 1 | Peripheral ready for beats |
| per_xfer | output | 1 | Beat taken this cycle |
| per_burst_end | output | 1 | Burst or buffer boundary reached on this beat |
| per_rdata | input | 16 | Data from peripheral |
| per_wdata | output | 16 | Data toward peripheral |
| per_sel | output | 4 | Peripheral select |
| per_addr | output | 24 | Peripheral address |

## Verification
A wrong in-use bit or wrong start bit shows up at the ports within one cycle. `mem_addr` jumps to the wrong buffer, the summed beat addresses no longer match, and the status word returns an unexpected value on the next read. A count that steps wrongly changes the total number of beats and the count of `per_burst_end` pulses by the time the buffer completes. A missed completion hand-off shows up as a gap in the run of back-to-back beats in the cycle after the last beat of A. The selection rules for the next buffer to load and for the readback address are swept over every combination of the start bits for both values of in-use.

// File: rtl/dbuf_dma_pkg.sv
package dbuf_dma_pkg;

    localparam int DATA_W = 16;
    localparam int REG_AW = 6;

    localparam logic [REG_AW-1:0] OFS_SETUP  = 6'h00;
    localparam logic [REG_AW-1:0] OFS_SET    = 6'h04;
    localparam logic [REG_AW-1:0] OFS_CLR    = 6'h08;
    localparam logic [REG_AW-1:0] OFS_STAT   = 6'h0C;
    localparam logic [REG_AW-1:0] OFS_A_ADDR = 6'h10;
    localparam logic [REG_AW-1:0] OFS_A_CNT  = 6'h14;
    localparam logic [REG_AW-1:0] OFS_B_ADDR = 6'h18;
    localparam logic [REG_AW-1:0] OFS_B_CNT  = 6'h1C;
    localparam logic [REG_AW-1:0] OFS_CUR    = 6'h20;

    // control word, bit 7 down to bit 0
    typedef struct packed {
        logic inuse;
        logic strt_b;
        logic done_b;
        logic strt_a;
        logic done_a;
        logic err;
        logic ie;
        logic run;
    } ctrl_t;

    // low byte of the setup register, bit 7 down to bit 0
    typedef struct packed {
        logic [3:0] psel;
        logic       wide16;
        logic       burst8;
        logic       be;
        logic       dir;
    } setup_lo_t;

    localparam logic [7:0] SW_MASK = 8'h7F;

    function automatic logic [DATA_W-1:0] lane_swap(input logic [DATA_W-1:0] d,
                                                    input logic en);
        return en ? {d[7:0], d[15:8]} : d;
    endfunction

endpackage

// File: rtl/dbuf_dma_csr.sv
module dbuf_dma_csr
    import dbuf_dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       set_we,
    input  logic       clr_we,
    input  logic [7:0] wmask,
    input  logic [1:0] done_ev,
    input  logic       err_ev,
    input  logic       swap_ev,
    output ctrl_t      ctrl
);
    ctrl_t      nxt;
    logic [7:0] sw_bits;

    always_comb begin
        sw_bits = 8'(ctrl);
        if (set_we) sw_bits = sw_bits | (wmask & SW_MASK);
        if (clr_we) sw_bits = sw_bits & ~(wmask & SW_MASK);
        nxt = ctrl_t'(sw_bits);
        // hardware events take precedence over software in the same cycle
        if (done_ev[0]) begin
            nxt.done_a = 1'b1;
            nxt.strt_a = 1'b0;
        end
        if (done_ev[1]) begin
            nxt.done_b = 1'b1;
            nxt.strt_b = 1'b0;
        end
        if (err_ev) begin
            nxt.err = 1'b1;
            nxt.run = 1'b0;
        end
        if (swap_ev) nxt.inuse = ~ctrl.inuse;
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl <= '0;
        else     ctrl <= nxt;
    end
endmodule

// File: rtl/dbuf_dma_buf.sv
module dbuf_dma_buf #(
    parameter int AW = 32,
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          addr_we,
    input  logic          cnt_we,
    input  logic [31:0]   wdata,
    input  logic          step_en,
    input  logic [1:0]    step,
    output logic [AW-1:0] addr,
    output logic [CW-1:0] cnt
);
    logic [CW-1:0] step_c;
    assign step_c = CW'(step);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
            cnt  <= '0;
        end else begin
            if (addr_we)      addr <= wdata[AW-1:0];
            else if (step_en) addr <= addr + AW'(step);
            if (cnt_we)       cnt  <= wdata[CW-1:0];
            else if (step_en) cnt  <= (cnt <= step_c) ? '0 : cnt - step_c;
        end
    end
endmodule

// File: rtl/dbuf_dma_eng.sv
module dbuf_dma_eng #(
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          strt_a,
    input  logic          strt_b,
    input  logic          inuse,
    input  logic [CW-1:0] cnt_a,
    input  logic [CW-1:0] cnt_b,
    input  logic          burst8,
    input  logic          wide16,
    input  logic          per_req,
    input  logic          mem_ack,
    input  logic          mem_err,
    output logic          mem_req,
    output logic          beat,
    output logic          err_ev,
    output logic [1:0]    done_ev,
    output logic          swap_ev,
    output logic          burst_end,
    output logic [1:0]    step
);
    localparam int BC_W = 3;

    logic          cur_start, oth_start, active, last, fin;
    logic [CW-1:0] cur_cnt;
    logic [BC_W-1:0] bcnt, blen_m1;

    always_comb begin
        cur_start = inuse ? strt_b : strt_a;
        oth_start = inuse ? strt_a : strt_b;
        cur_cnt   = inuse ? cnt_b  : cnt_a;
        step      = wide16 ? 2'd2 : 2'd1;
        blen_m1   = burst8 ? BC_W'(7) : BC_W'(3);
        active    = run && cur_start;
        mem_req   = active && (cur_cnt != '0) && per_req;
        beat      = mem_req && mem_ack && !mem_err;
        err_ev    = mem_req && mem_ack && mem_err;
        last      = beat && (cur_cnt <= CW'(step));
        fin       = last || (active && (cur_cnt == '0));
        done_ev   = '0;
        done_ev[inuse] = fin;
        swap_ev   = run && oth_start && (fin || !cur_start);
        burst_end = beat && ((bcnt == blen_m1) || last);
    end

    always_ff @(posedge clk) begin
        if (rst)       bcnt <= '0;
        else if (beat) bcnt <= burst_end ? '0 : bcnt + 1'b1;
    end
endmodule

// File: rtl/dbuf_dma_chan.sv
module dbuf_dma_chan
    import dbuf_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 13
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic                reg_we,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic                irq,
    output logic                load_sel,
    output logic                mem_req,
    input  logic                mem_ack,
    input  logic                mem_err,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_we,
    output logic                mem_wide,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    input  logic                per_req,
    output logic                per_xfer,
    output logic                per_burst_end,
    input  logic [DATA_W-1:0]   per_rdata,
    output logic [DATA_W-1:0]   per_wdata,
    output logic [3:0]          per_sel,
    output logic [ADDR_W-9:0]   per_addr
);
    localparam int NBUF = 2;

    ctrl_t              ctrl;
    logic [ADDR_W-1:0]  setup;
    setup_lo_t          cfg;
    logic [ADDR_W-1:0]  buf_addr [NBUF];
    logic [CNT_W-1:0]   buf_cnt  [NBUF];
    logic               beat, err_ev, swap_ev;
    logic [1:0]         done_ev, step;
    logic               sel_a_cur;
    logic [ADDR_W-1:0]  cur_addr;

    assign cfg = setup_lo_t'(setup[7:0]);

    always_ff @(posedge clk) begin
        if (rst)                                  setup <= '0;
        else if (reg_we && reg_addr == OFS_SETUP) setup <= reg_wdata[ADDR_W-1:0];
    end

    dbuf_dma_csr u_csr (
        .clk     (clk),
        .rst     (rst),
        .set_we  (reg_we && reg_addr == OFS_SET),
        .clr_we  (reg_we && reg_addr == OFS_CLR),
        .wmask   (reg_wdata[7:0]),
        .done_ev (done_ev),
        .err_ev  (err_ev),
        .swap_ev (swap_ev),
        .ctrl    (ctrl)
    );

    for (genvar i = 0; i < NBUF; i++) begin : g_buf
        localparam logic [REG_AW-1:0] OA = (i == 0) ? OFS_A_ADDR : OFS_B_ADDR;
        localparam logic [REG_AW-1:0] OC = (i == 0) ? OFS_A_CNT  : OFS_B_CNT;
        dbuf_dma_buf #(.AW(ADDR_W), .CW(CNT_W)) u_buf (
            .clk     (clk),
            .rst     (rst),
            .addr_we (reg_we && reg_addr == OA),
            .cnt_we  (reg_we && reg_addr == OC),
            .wdata   (reg_wdata),
            .step_en (beat && (ctrl.inuse == 1'(i))),
            .step    (step),
            .addr    (buf_addr[i]),
            .cnt     (buf_cnt[i])
        );
    end

    dbuf_dma_eng #(.CW(CNT_W)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .run       (ctrl.run),
        .strt_a    (ctrl.strt_a),
        .strt_b    (ctrl.strt_b),
        .inuse     (ctrl.inuse),
        .cnt_a     (buf_cnt[0]),
        .cnt_b     (buf_cnt[1]),
        .burst8    (cfg.burst8),
        .wide16    (cfg.wide16),
        .per_req   (per_req),
        .mem_ack   (mem_ack),
        .mem_err   (mem_err),
        .mem_req   (mem_req),
        .beat      (beat),
        .err_ev    (err_ev),
        .done_ev   (done_ev),
        .swap_ev   (swap_ev),
        .burst_end (per_burst_end),
        .step      (step)
    );

    always_comb begin
        sel_a_cur = (!ctrl.inuse && ctrl.strt_a) || (ctrl.inuse && !ctrl.strt_b);
        cur_addr  = sel_a_cur ? buf_addr[0] : buf_addr[1];
        load_sel  = !((ctrl.inuse && ctrl.strt_b) || (!ctrl.inuse && !ctrl.strt_a));
        irq       = ctrl.ie && (ctrl.err || ctrl.done_a || ctrl.done_b);
        mem_addr  = ctrl.inuse ? buf_addr[1] : buf_addr[0];
        mem_we    = cfg.dir;
        mem_wide  = cfg.wide16;
        per_xfer  = beat;
        per_sel   = cfg.psel;
        per_addr  = setup[ADDR_W-1:8];
        mem_wdata = lane_swap(per_rdata, cfg.wide16 && cfg.be);
        per_wdata = lane_swap(mem_rdata, cfg.wide16 && cfg.be);
    end

    always_comb begin
        case (reg_addr)
            OFS_SETUP:  reg_rdata = 32'(setup);
            OFS_STAT:   reg_rdata = 32'(ctrl);
            OFS_A_ADDR: reg_rdata = 32'(buf_addr[0]);
            OFS_A_CNT:  reg_rdata = 32'(buf_cnt[0]);
            OFS_B_ADDR: reg_rdata = 32'(buf_addr[1]);
            OFS_B_CNT:  reg_rdata = 32'(buf_cnt[1]);
            OFS_CUR:    reg_rdata = 32'(cur_addr);
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dbuf_dma_chk.sv
module dbuf_dma_chk #(
    parameter int AW = 32,
    parameter int CW = 13
) (
    input logic          clk,
    input logic          rst,
    input logic          run,
    input logic          ie,
    input logic          err,
    input logic          strt_a,
    input logic          strt_b,
    input logic          inuse,
    input logic          reg_we,
    input logic          mem_req,
    input logic          mem_ack,
    input logic          mem_err,
    input logic          irq,
    input logic [AW-1:0] addr_a,
    input logic [AW-1:0] addr_b,
    input logic [CW-1:0] cnt_a,
    input logic [CW-1:0] cnt_b
);
    AST_REQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (run && (inuse ? strt_b : strt_a)));                       // R3

    AST_COUNT_FALLS_A: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && !mem_err && !reg_we && !inuse) |=> (cnt_a < $past(cnt_a))); // R3

    AST_ERR_HALTS: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && mem_err) |=> (!run && err));                   // R9

    AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!run && !reg_we) |=> ($stable(addr_a) && $stable(addr_b) &&
                               $stable(cnt_a) && $stable(cnt_b)));            // R8

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq |-> ie);                                                           // R5
endmodule

bind dbuf_dma_chan dbuf_dma_chk #(.AW(ADDR_W), .CW(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .run     (ctrl.run),
    .ie      (ctrl.ie),
    .err     (ctrl.err),
    .strt_a  (ctrl.strt_a),
    .strt_b  (ctrl.strt_b),
    .inuse   (ctrl.inuse),
    .reg_we  (reg_we),
    .mem_req (mem_req),
    .mem_ack (mem_ack),
    .mem_err (mem_err),
    .irq     (irq),
    .addr_a  (buf_addr[0]),
    .addr_b  (buf_addr[1]),
    .cnt_a   (buf_cnt[0]),
    .cnt_b   (buf_cnt[1])
);

// File: tb/sim_dbuf_dma_chan.sv
module sim_dbuf_dma_chan;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, load_sel, mem_req, mem_we, mem_wide, per_xfer, per_burst_end;
    logic        mem_ack = 1'b1, mem_err = 1'b0, per_req = 1'b1;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata, per_wdata;
    logic [15:0] mem_rdata = '0, per_rdata = '0;
    logic [3:0]  per_sel;
    logic [23:0] per_addr;

    int checks = 0, fails = 0, cyc = 0;
    int beats = 0, ends = 0, gaps = 0, last_cyc = -10;
    longint addr_sum = 0;

    always #2 clk = ~clk;

    dbuf_dma_chan u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .load_sel(load_sel),
        .mem_req(mem_req), .mem_ack(mem_ack), .mem_err(mem_err), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_wide(mem_wide), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .per_req(per_req), .per_xfer(per_xfer), .per_burst_end(per_burst_end),
        .per_rdata(per_rdata), .per_wdata(per_wdata), .per_sel(per_sel), .per_addr(per_addr)
    );

    // beat monitor
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst && mem_req && mem_ack && !mem_err) begin
            if (last_cyc != cyc - 1) gaps = gaps + 1;
            last_cyc = cyc;
            beats    = beats + 1;
            addr_sum = addr_sum + longint'(mem_addr);
            if (per_burst_end) ends = ends + 1;
        end
        if (cyc > 150000) begin
            $display("FAIL watchdog: run did not finish, actual=%0d expected<=150000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
            $finish;
        end
    end

    task automatic chk(input longint act, input longint exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #0.5 d = reg_rdata;
    endtask

    task automatic wait_bits(input logic [7:0] m, input string what);
        logic [31:0] v;
        bit ok = 0;
        for (int i = 0; i < 3000; i++) begin
            rd(6'h0C, v);
            if ((v[7:0] & m) == m) begin ok = 1; break; end
        end
        chk(ok, 1, what);
    endtask

    initial begin
        logic [31:0] v;
        int b0, e0, g0, bp;
        longint s0;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(6'h0C, v); chk(v, 0, "R1 status after reset");
        rd(6'h00, v); chk(v, 0, "R1 setup after reset");
        rd(6'h10, v); chk(v, 0, "R1 A address after reset");
        rd(6'h1C, v); chk(v, 0, "R1 B count after reset");
        rd(6'h20, v); chk(v, 0, "R1 readback after reset");
        chk({irq, mem_req, load_sel}, 0, "R1 irq/mem_req/load_sel after reset");

        // R2 set/clear/read offsets
        wr(6'h04, 32'h02); rd(6'h0C, v); chk(v, 32'h02, "R2 set ie");
        wr(6'h04, 32'h00); rd(6'h0C, v); chk(v, 32'h02, "R2 set of zeros");
        wr(6'h08, 32'h00); rd(6'h0C, v); chk(v, 32'h02, "R2 clear of zeros");
        wr(6'h04, 32'h80); rd(6'h0C, v); chk(v, 32'h02, "R2 in-use not writable");
        wr(6'h08, 32'h02); rd(6'h0C, v); chk(v, 32'h00, "R2 clear ie");
        // R5 interrupt gating
        wr(6'h04, 32'h2C); chk(irq, 0, "R5 flags without enable");
        wr(6'h04, 32'h02); chk(irq, 1, "R5 flags with enable");
        wr(6'h08, 32'h28); chk(irq, 1, "R5 error flag alone");
        wr(6'h08, 32'h04); chk(irq, 0, "R5 all flags cleared");
        wr(6'h08, 32'h02);

        // R6 / R7 sweep, in-use = 0
        wr(6'h10, 32'h1000); wr(6'h18, 32'h2000);
        for (int sa = 0; sa < 2; sa++)
            for (int sb = 0; sb < 2; sb++) begin
                wr(6'h08, 32'h50);
                wr(6'h04, 32'((sa << 4) | (sb << 6)));
                chk(load_sel, (sa == 0) ? 0 : 1, $sformatf("R6 inuse0 sa%0d sb%0d", sa, sb));
                rd(6'h20, v);
                chk(v, (sa == 1) ? 32'h1000 : 32'h2000, $sformatf("R7 inuse0 sa%0d sb%0d", sa, sb));
            end
        wr(6'h08, 32'h50);

        // R3 R4 R10: 8-bit single buffer, memory to peripheral
        wr(6'h00, 32'h0); wr(6'h10, 32'h100); wr(6'h14, 32'd5);
        b0 = beats; s0 = addr_sum; e0 = ends;
        wr(6'h04, 32'h13);
        wait_bits(8'h08, "R4 done A raised");
        chk(beats - b0, 5, "R3 beat count 8-bit");
        chk(addr_sum - s0, 5 * 32'h100 + 10, "R3 address sequence 8-bit");
        chk(ends - e0, 2, "R10 burst4 ends for 5 beats");
        chk(mem_we, 0, "R3 direction memory to peripheral");
        rd(6'h0C, v); chk(v, 32'h0B, "R4 status after A completes");
        chk(irq, 1, "R5 irq on done");
        rd(6'h14, v); chk(v, 0, "R3 A count drained");
        rd(6'h10, v); chk(v, 32'h105, "R3 A address advanced");
        wr(6'h08, 32'h08);

        // R3 16-bit with odd count
        wr(6'h00, 32'h08); wr(6'h10, 32'h200); wr(6'h14, 32'd5);
        b0 = beats; s0 = addr_sum; e0 = ends;
        wr(6'h04, 32'h10);
        wait_bits(8'h08, "R4 done A 16-bit");
        chk(beats - b0, 3, "R3 beat count 16-bit odd");
        chk(addr_sum - s0, 3 * 32'h200 + 6, "R3 address step 2");
        chk(ends - e0, 1, "R10 last-beat end");
        rd(6'h10, v); chk(v, 32'h206, "R3 A address after 16-bit");
        wr(6'h08, 32'h08);

        // R4 gapless A->B, burst 8
        wr(6'h00, 32'h04); wr(6'h10, 32'h300); wr(6'h14, 32'd6);
        wr(6'h18, 32'h400); wr(6'h1C, 32'd4);
        b0 = beats; s0 = addr_sum; e0 = ends; g0 = gaps;
        wr(6'h04, 32'h50);
        wait_bits(8'h20, "R4 done B raised");
        chk(beats - b0, 10, "R4 beats over both buffers");
        chk(addr_sum - s0, 6 * 32'h300 + 15 + 4 * 32'h400 + 6, "R4 addresses A then B");
        chk(gaps - g0, 1, "R4 no gap at buffer switch");
        chk(ends - e0, 2, "R10 burst8 ends");
        rd(6'h0C, v); chk(v, 32'hAB, "R4 status after A and B");
        wr(6'h08, 32'h29);

        // R6 / R7 sweep, in-use = 1, run = 0
        for (int sa = 0; sa < 2; sa++)
            for (int sb = 0; sb < 2; sb++) begin
                wr(6'h08, 32'h50);
                wr(6'h04, 32'((sa << 4) | (sb << 6)));
                chk(load_sel, (sb == 1) ? 0 : 1, $sformatf("R6 inuse1 sa%0d sb%0d", sa, sb));
                rd(6'h20, v);
                chk(v, (sb == 0) ? 32'h306 : 32'h404, $sformatf("R7 inuse1 sa%0d sb%0d", sa, sb));
            end
        wr(6'h08, 32'h50);

        // R4 hand-over to started other buffer, zero count
        wr(6'h14, 32'd0);
        b0 = beats;
        wr(6'h04, 32'h11);
        wait_bits(8'h08, "R4 zero-count done");
        chk(beats - b0, 0, "R4 zero count issues no beat");
        rd(6'h0C, v); chk(v, 32'h0B, "R4 in-use back to A");
        wr(6'h08, 32'h08);

        // R8 pause / resume
        wr(6'h00, 32'h0); wr(6'h10, 32'h500); wr(6'h14, 32'd20);
        per_req = 1'b0;
        b0 = beats; s0 = addr_sum; e0 = ends;
        wr(6'h04, 32'h10);
        repeat (3) @(negedge clk);
        chk(beats - b0, 0, "R3 no beats without per_req");
        per_req = 1'b1;
        while (beats - b0 < 4) @(negedge clk);
        per_req = 1'b0;
        bp = beats - b0;
        wr(6'h08, 32'h01);
        per_req = 1'b1;
        repeat (8) @(negedge clk);
        chk(beats - b0, bp, "R8 no beats while paused");
        chk(mem_req, 0, "R8 no request while paused");
        rd(6'h14, v); chk(v, 20 - bp, "R8 count held");
        rd(6'h10, v); chk(v, 32'h500 + bp, "R8 address held");
        wr(6'h04, 32'h01);
        wait_bits(8'h08, "R8 done after resume");
        chk(beats - b0, 20, "R8 total beats after resume");
        chk(addr_sum - s0, 20 * 32'h500 + 190, "R8 addresses no loss or repeat");
        chk(ends - e0, 5, "R10 burst4 ends over 20 beats");
        wr(6'h08, 32'h08);

        // R9 error response
        wr(6'h10, 32'h600); wr(6'h14, 32'd8);
        b0 = beats;
        wr(6'h04, 32'h10);
        while (beats - b0 < 2) @(negedge clk);
        mem_err = 1'b1;
        @(negedge clk);
        mem_err = 1'b0;
        bp = beats - b0;
        rd(6'h0C, v);
        chk(v[2:0], 3'b110, "R9 error set, run cleared");
        chk(irq, 1, "R9 irq on error");
        repeat (4) @(negedge clk);
        chk(beats - b0, bp, "R9 channel stopped");
        rd(6'h14, v); chk(v, 8 - bp, "R9 error beat not counted");
        wr(6'h08, 32'h1C);
        chk(irq, 0, "R9 irq cleared");

        // R11 byte lanes
        mem_rdata = 16'h12AB; per_rdata = 16'h3C5D;
        wr(6'h00, 32'h0A);
        chk(per_wdata, 16'hAB12, "R11 swap to peripheral");
        chk(mem_wdata, 16'h5D3C, "R11 swap to memory");
        wr(6'h00, 32'h08);
        chk(per_wdata, 16'h12AB, "R11 little-endian 16-bit");
        wr(6'h00, 32'h03);
        chk(mem_wdata, 16'h3C5D, "R11 8-bit passes through");
        chk(mem_we, 1, "R3 direction peripheral to memory");

        // R12 setup fields
        wr(6'h00, 32'hABCDE0F4);
        chk(per_sel, 4'hF, "R12 peripheral select");
        chk(per_addr, 24'hABCDE0, "R12 peripheral address");
        rd(6'h00, v); chk(v, 32'hABCDE0F4, "R12 setup readback");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule